// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach a small register subsystem that has 8-bit addresses and runs on a slower clock. The host does not address subsystem registers directly. It writes a command word that names the target address, the direction and the byte lanes. It then either writes the data, which launches a write, or launches a read with the command itself and collects the returned bytes from the data registers. While a transfer is outstanding, a busy bit in the command word reads as 1. The host polls this bit before it touches the bridge again.

Towards the subsystem, the bridge uses a two-phase toggle handshake. Each transfer flips the request line. The transfer is complete when the acknowledge line, after a synchroniser chain, matches the request again. Address, write data, byte lanes and direction stay frozen for the whole transfer. The bridge also turns completed transfers and rising edges of the subsystem interrupt line into sticky flags. The flags are cleared by writing 1 and are masked by an enable register into a single interrupt output.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the command word (offset 0x04), both data words (0x08 lower, 0x0C upper), the interrupt enable (0x10) and the interrupt flags (0x14) read 0, `irq_out` is 0, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: The command word holds the subsystem address in bits 7:0, the lower-word byte enables in bits 19:16, the upper-word byte enables in bits 23:20, direction in bit 24 (1 = read, 0 = write) and size in bit 25 (1 = both words take part). It reads back as written, except that bit 31 shows busy and every other bit reads 0.
- R3: Writing a command with direction 0 starts nothing. A write transfer starts when the lower data word (0x08) is written while the held command has direction 0. Writing the upper data word never starts a transfer, and neither does writing the lower word while the held direction is 1.
- R4: Writing a command with direction 1 starts a read. When busy clears, each lower-data byte whose lower enable bit is set holds the returned byte. With size 1, the same applies to upper-data bytes under the upper enables. Every other byte keeps its previous value.
- R5: Bit 31 of the command word is 1 from the start of a transfer until the synchronised acknowledge matches the request. Every start flips `sub_req`.
- R6: While busy, host writes to the command and data words are ignored.
- R7: `sub_be[3:0]` carries the lower enables. `sub_be[7:4]` carries the upper enables when size is 1 and is 0 when size is 0. The subsystem writes only the enabled byte lanes.
- R8: Flag bit 1 is set by a rising edge of the synchronised `sub_irq`, and flag bit 0 is set when a transfer completes. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_out` is 1 exactly when some flag bit and the enable bit at the same position (bits 1:0) are both 1.
- R10: `sub_addr`, `sub_we`, `sub_be` and `sub_wdata` stay unchanged while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | HADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| sub_req | output | 1 | Request toggle to the subsystem |
| sub_we | output | 1 | 1 = subsystem write |
| sub_addr | output | 8 | Subsystem register address |
| sub_be | output | 8 | Byte lanes, upper word in bits 7:4 |
| sub_wdata | output | 64 | Write data, upper word in bits 63:32 |
| sub_ack | input | 1 | Acknowledge toggle from the subsystem |
| sub_rdata | input | 64 | Read data, held stable after an ack toggle |
| sub_irq | input | 1 | Subsystem interrupt level |
| irq_out | output | 1 | Masked interrupt output |

## Verification
The main function is driven by a table of write transfers. The table mixes full 64-bit lane sets, lower-only lanes with size 0 and sparse byte patterns, and each write is followed by a full-width readback. This separates correct lane masking from lanes leaking in, and shows whether the upper enables are gated by size. A read with a sparse lower enable, issued over preloaded data, shows that disabled bytes keep their old value. A slow acknowledge stretches busy long enough to prove that command and data writes inside the window are dropped. Interrupt tests hold `sub_irq` high through a clear, which tells edge detection apart from level sensing.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int SUB_AW   = 8;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int IRQ_SRCS = 2;

    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h04;
    localparam logic [7:0] OFS_LO   = 8'h08;
    localparam logic [7:0] OFS_HI   = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h10;
    localparam logic [7:0] OFS_IFLG = 8'h14;

    localparam int BIT_BUSY = 31;
    localparam int BIT_SIZE = 25;
    localparam int BIT_DIR  = 24;
    localparam int BEH_LSB  = 20;
    localparam int BEL_LSB  = 16;

    typedef enum logic [2:0] {
        SEL_ID, SEL_CTRL, SEL_LO, SEL_HI, SEL_IEN, SEL_IFLG, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              size;
        logic              dir;
        logic [LANES-1:0]  be_hi;
        logic [LANES-1:0]  be_lo;
        logic [SUB_AW-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic                we;
        logic [2*LANES-1:0]  be;
        logic [SUB_AW-1:0]   addr;
        logic [2*WORD_W-1:0] wdata;
    } xfer_t;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        case (off)
            OFS_ID:   return SEL_ID;
            OFS_CTRL: return SEL_CTRL;
            OFS_LO:   return SEL_LO;
            OFS_HI:   return SEL_HI;
            OFS_IEN:  return SEL_IEN;
            OFS_IFLG: return SEL_IFLG;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic cmd_t cmd_unpack(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.size  = w[BIT_SIZE];
        c.dir   = w[BIT_DIR];
        c.be_hi = w[BEH_LSB +: LANES];
        c.be_lo = w[BEL_LSB +: LANES];
        c.addr  = w[SUB_AW-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_pack(input cmd_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_BUSY]          = busy;
        w[BIT_SIZE]          = c.size;
        w[BIT_DIR]           = c.dir;
        w[BEH_LSB +: LANES]  = c.be_hi;
        w[BEL_LSB +: LANES]  = c.be_lo;
        w[SUB_AW-1:0]        = c.addr;
        return w;
    endfunction

    function automatic logic [2*LANES-1:0] lane_set(input cmd_t c);
        return {(c.size ? c.be_hi : {LANES{1'b0}}), c.be_lo};
    endfunction

    function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [LANES-1:0]  be);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/brg_xfer_ctrl.sv
module brg_xfer_ctrl
    import brg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  xfer_t start_xfer,
    input  logic  sub_ack,
    output logic  sub_req,
    output xfer_t sub_xfer,
    output logic  busy,
    output logic  done
);
    logic  req_q;
    logic  ack_s;
    logic  busy_q;
    xfer_t held_q;

    brg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (sub_ack),
        .q   (ack_s)
    );

    assign done = busy_q && (ack_s == req_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            busy_q <= 1'b0;
            held_q <= '0;
        end else if (start && !busy_q) begin
            req_q  <= ~req_q;
            busy_q <= 1'b1;
            held_q <= start_xfer;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    assign sub_req  = req_q;
    assign sub_xfer = held_q;
    assign busy     = busy_q;

    // R5: a new transfer is only requested when idle, and it flips the request
    a_r5_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);
    a_r5_req_flips: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (sub_req != $past(sub_req)));
    // R10: outgoing request fields frozen while busy
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (!busy_q || ($stable(sub_xfer) && $stable(sub_req))));
endmodule

// File: rtl/brg_irq_ctrl.sv
module brg_irq_ctrl
    import brg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sub_irq,
    input  logic                xfer_done,
    input  logic                en_wr,
    input  logic                flg_wr,
    input  logic [IRQ_SRCS-1:0] wbits,
    output logic [IRQ_SRCS-1:0] en_q,
    output logic [IRQ_SRCS-1:0] flg_q,
    output logic                irq_out
);
    logic irq_s;
    logic irq_d;
    logic irq_rise;
    logic [IRQ_SRCS-1:0] set_v;
    logic [IRQ_SRCS-1:0] clr_v;

    brg_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk (clk),
        .rst (rst),
        .d   (sub_irq),
        .q   (irq_s)
    );

    assign irq_rise = irq_s && !irq_d;
    assign set_v    = {irq_rise, xfer_done};
    assign clr_v    = flg_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_d <= 1'b0;
            en_q  <= '0;
            flg_q <= '0;
        end else begin
            irq_d <= irq_s;
            if (en_wr) en_q <= wbits;
            flg_q <= (flg_q & ~clr_v) | set_v;
        end
    end

    assign irq_out = |(flg_q & en_q);

    // R8: rising edge of the subsystem line sets flag bit 1
    a_r8_edge_sets: assert property (@(posedge clk) disable iff (rst)
        irq_rise |=> flg_q[1]);
    // R8: write-one clears when no new event arrives
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (flg_wr && wbits[1] && !irq_rise) |=> !flg_q[1]);
    // R9: no flag, no interrupt
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (flg_q == '0) |-> !irq_out);
endmodule

// File: rtl/brg_host_regs.sv
module brg_host_regs
    import brg_pkg::*;
#(
    parameter int               HADDR_W  = 8,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h0B51_0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_sel,
    input  logic                host_wr,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [2*WORD_W-1:0] sub_rdata,
    input  logic [IRQ_SRCS-1:0] en_q,
    input  logic [IRQ_SRCS-1:0] flg_q,
    output logic                start,
    output xfer_t               start_xfer,
    output logic                en_wr,
    output logic                flg_wr
);
    reg_sel_e          sel;
    cmd_t              cmd_q;
    cmd_t              cmd_new;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic              wr_ok;
    logic              rd_launch;
    logic              wr_launch;

    assign sel     = decode_off(8'(host_addr));
    assign cmd_new = cmd_unpack(host_wdata);
    assign wr_ok   = host_sel && host_wr && !busy;

    assign rd_launch = wr_ok && (sel == SEL_CTRL) && cmd_new.dir;
    assign wr_launch = wr_ok && (sel == SEL_LO) && !cmd_q.dir;
    assign start     = rd_launch || wr_launch;

    always_comb begin
        start_xfer = '0;
        if (rd_launch) begin
            start_xfer.we    = 1'b0;
            start_xfer.be    = lane_set(cmd_new);
            start_xfer.addr  = cmd_new.addr;
            start_xfer.wdata = {hi_q, lo_q};
        end else begin
            start_xfer.we    = 1'b1;
            start_xfer.be    = lane_set(cmd_q);
            start_xfer.addr  = cmd_q.addr;
            start_xfer.wdata = {hi_q, host_wdata};
        end
    end

    assign en_wr  = host_sel && host_wr && (sel == SEL_IEN);
    assign flg_wr = host_sel && host_wr && (sel == SEL_IFLG);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (done) begin
            if (!cmd_q.dir) begin
                lo_q <= lo_q;
            end else begin
                lo_q <= byte_merge(lo_q, sub_rdata[WORD_W-1:0], cmd_q.be_lo);
                if (cmd_q.size)
                    hi_q <= byte_merge(hi_q, sub_rdata[2*WORD_W-1:WORD_W], cmd_q.be_hi);
            end
        end else if (wr_ok) begin
            case (sel)
                SEL_CTRL: cmd_q <= cmd_new;
                SEL_LO:   lo_q  <= host_wdata;
                SEL_HI:   hi_q  <= host_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:   host_rdata = ID_VALUE;
            SEL_CTRL: host_rdata = cmd_pack(cmd_q, busy);
            SEL_LO:   host_rdata = lo_q;
            SEL_HI:   host_rdata = hi_q;
            SEL_IEN:  host_rdata = {{(WORD_W-IRQ_SRCS){1'b0}}, en_q};
            SEL_IFLG: host_rdata = {{(WORD_W-IRQ_SRCS){1'b0}}, flg_q};
            default:  host_rdata = '0;
        endcase
    end

    // R6: command held while a transfer is in flight
    a_r6_cmd_kept: assert property (@(posedge clk) disable iff (rst)
        (busy && host_sel && host_wr && (sel == SEL_CTRL)) |=> $stable(cmd_q));
    // R6: data write during a write transfer does not disturb the data words
    a_r6_data_kept: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_q.dir && host_sel && host_wr && (sel == SEL_LO || sel == SEL_HI))
            |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import brg_pkg::*;
#(
    parameter int                HADDR_W     = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] ID_VALUE    = 32'h0B51_0001
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_sel,
    input  logic                  host_wr,
    input  logic [HADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  sub_req,
    output logic                  sub_we,
    output logic [SUB_AW-1:0]     sub_addr,
    output logic [2*LANES-1:0]    sub_be,
    output logic [2*WORD_W-1:0]   sub_wdata,
    input  logic                  sub_ack,
    input  logic [2*WORD_W-1:0]   sub_rdata,
    input  logic                  sub_irq,
    output logic                  irq_out
);
    logic                start;
    xfer_t               start_xfer;
    xfer_t               sub_xfer;
    logic                busy;
    logic                done;
    logic                en_wr;
    logic                flg_wr;
    logic [IRQ_SRCS-1:0] en_q;
    logic [IRQ_SRCS-1:0] flg_q;

    brg_host_regs #(
        .HADDR_W  (HADDR_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .sub_rdata  (sub_rdata),
        .en_q       (en_q),
        .flg_q      (flg_q),
        .start      (start),
        .start_xfer (start_xfer),
        .en_wr      (en_wr),
        .flg_wr     (flg_wr)
    );

    brg_xfer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_xfer (start_xfer),
        .sub_ack    (sub_ack),
        .sub_req    (sub_req),
        .sub_xfer   (sub_xfer),
        .busy       (busy),
        .done       (done)
    );

    brg_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .sub_irq   (sub_irq),
        .xfer_done (done),
        .en_wr     (en_wr),
        .flg_wr    (flg_wr),
        .wbits     (host_wdata[IRQ_SRCS-1:0]),
        .en_q      (en_q),
        .flg_q     (flg_q),
        .irq_out   (irq_out)
    );

    assign sub_we    = sub_xfer.we;
    assign sub_addr  = sub_xfer.addr;
    assign sub_be    = sub_xfer.be;
    assign sub_wdata = sub_xfer.wdata;
endmodule

// File: tb/ind_reg_bridge_test.sv
module ind_reg_bridge_test;
    localparam logic [31:0] ID_V = 32'h0B51_0001;
    localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h04, A_LO = 8'h08,
                           A_HI = 8'h0C, A_IEN = 8'h10, A_IFLG = 8'h14;

    // {addr8, be_hi4, be_lo4, size1, data64}
    localparam int NVEC = 6;
    localparam logic [80:0] VEC [NVEC] = '{
        {8'h10, 4'hF, 4'hF, 1'b1, 64'h11223344_55667788},
        {8'h11, 4'h0, 4'hF, 1'b0, 64'hAAAAAAAA_CAFEF00D},
        {8'h10, 4'h0, 4'h5, 1'b0, 64'h00000000_99AABBCC},
        {8'hFF, 4'hA, 4'h3, 1'b1, 64'hDEADBEEF_01234567},
        {8'h00, 4'hF, 4'hF, 1'b1, 64'h0F0F0F0F_F0F0F0F0},
        {8'h11, 4'hC, 4'h0, 1'b1, 64'h12345678_9ABCDEF0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_sel = 1'b0, host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic sub_req, sub_we;
    logic [7:0] sub_addr, sub_be;
    logic [63:0] sub_wdata;
    logic sub_ack = 1'b0;
    logic [63:0] sub_rdata = '0;
    logic sub_irq = 1'b0;
    logic irq_out;

    int checks = 0;
    int fails = 0;
    int lat = 3;
    logic [63:0] model_mem [256];
    logic [63:0] exp_mem [256];
    logic [7:0] last_be;

    always #2 clk = ~clk;

    ind_reg_bridge #(.ID_VALUE(ID_V)) uut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sub_req(sub_req), .sub_we(sub_we), .sub_addr(sub_addr), .sub_be(sub_be),
        .sub_wdata(sub_wdata), .sub_ack(sub_ack), .sub_rdata(sub_rdata),
        .sub_irq(sub_irq), .irq_out(irq_out)
    );

    // Subsystem model: toggle handshake, lane-masked register array
    initial begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < 256; i++) model_mem[i] = '0;
        forever begin
            @(posedge clk);
            if (!rst && sub_req !== seen) begin
                seen = sub_req;
                repeat (lat) @(posedge clk);
                last_be = sub_be;
                if (sub_we) begin
                    for (int b = 0; b < 8; b++)
                        if (sub_be[b]) model_mem[sub_addr][8*b +: 8] = sub_wdata[8*b +: 8];
                end else begin
                    sub_rdata <= model_mem[sub_addr];
                end
                sub_ack <= ~sub_ack;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        host_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            hr(A_CTRL, v);
            if (!v[31]) break;
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic size, input logic dir,
                                           input logic [3:0] bh, input logic [3:0] bl,
                                           input logic [7:0] a);
        return {6'b0, size, dir, bh, bl, 8'h00, a};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, cmd;
        logic        r0;
        logic [7:0]  a, be8;
        logic [3:0]  bh, bl;
        logic        sz;
        logic [63:0] d, pre;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        hr(A_ID, v);   chk("R1 id", v, ID_V);
        hr(A_CTRL, v); chk("R1 ctrl", v, 0);
        hr(A_LO, v);   chk("R1 lo", v, 0);
        hr(A_HI, v);   chk("R1 hi", v, 0);
        hr(A_IEN, v);  chk("R1 ien", v, 0);
        hr(A_IFLG, v); chk("R1 iflg", v, 0);
        chk("R1 irq_out", irq_out, 0);

        // R2 layout, R3 command write alone starts nothing
        r0 = sub_req;
        hw(A_CTRL, 32'h4235_FFA5);
        repeat (6) @(posedge clk);
        hr(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0235_00A5);
        chk("R3 no req on cmd write", sub_req, r0);
        hw(A_HI, 32'h5555_5555);
        repeat (6) @(posedge clk);
        chk("R3 no req on upper write", sub_req, r0);

        // Table walk: write transfer then full readback
        for (int k = 0; k < NVEC; k++) begin
            {a, bh, bl, sz, d} = VEC[k];
            be8 = {sz ? bh : 4'h0, bl};
            hw(A_CTRL, mk_cmd(sz, 1'b0, bh, bl, a));
            hw(A_HI, d[63:32]);
            hw(A_LO, d[31:0]);
            wait_idle();
            chk("R7 sub_be lanes", last_be, be8);
            for (int b = 0; b < 8; b++)
                if (be8[b]) exp_mem[a][8*b +: 8] = d[8*b +: 8];
            hw(A_CTRL, mk_cmd(1'b1, 1'b1, 4'hF, 4'hF, a));
            wait_idle();
            hr(A_LO, v); chk("R4 R3 readback lo", v, exp_mem[a][31:0]);
            hr(A_HI, v); chk("R4 R7 readback hi", v, exp_mem[a][63:32]);
        end

        // R8 completion flag, R9 enable masking
        hr(A_IFLG, v); chk("R8 done flag", v[0], 1'b1);
        hw(A_IEN, 32'h1);
        #1 chk("R9 irq enabled bit0", irq_out, 1'b1);
        hw(A_IFLG, 32'h1);
        hr(A_IFLG, v); chk("R8 w1c bit0", v, 0);
        chk("R9 irq after clear", irq_out, 1'b0);

        // R3 lower write with held read direction starts nothing; R4 partial read
        r0 = sub_req;
        hw(A_LO, 32'hFFFF_FFFF);
        repeat (6) @(posedge clk);
        chk("R3 no req when dir read", sub_req, r0);
        pre = exp_mem[8'h10];
        hw(A_CTRL, mk_cmd(1'b0, 1'b1, 4'hF, 4'h2, 8'h10));
        wait_idle();
        hr(A_LO, v); chk("R4 partial lanes", v, {16'hFFFF, pre[15:8], 8'hFF});

        // R5 busy window, R6 writes ignored, R10 outputs held
        lat = 12;
        cmd = mk_cmd(1'b1, 1'b1, 4'hF, 4'hF, 8'hFF);
        hw(A_CTRL, cmd);
        hr(A_CTRL, v); chk("R5 busy set", v[31], 1'b1);
        hw(A_CTRL, mk_cmd(1'b0, 1'b0, 4'h1, 4'h1, 8'h33));
        hw(A_LO, 32'h1212_1212);
        hw(A_HI, 32'h3434_3434);
        chk("R10 addr held", sub_addr, 8'hFF);
        chk("R10 we held", sub_we, 1'b0);
        wait_idle();
        hr(A_CTRL, v); chk("R6 R5 cmd kept busy clear", v, cmd);
        hr(A_LO, v); chk("R6 lo not overwritten", v, exp_mem[8'hFF][31:0]);
        hr(A_HI, v2); chk("R6 hi not overwritten", v2, exp_mem[8'hFF][63:32]);
        lat = 3;

        // R8 edge-sensed subsystem interrupt, R9 masking
        hw(A_IFLG, 32'h3);
        hw(A_IEN, 32'h1);
        sub_irq = 1'b1;
        repeat (5) @(posedge clk);
        hr(A_IFLG, v); chk("R8 irq edge sets bit1", v, 32'h2);
        chk("R9 bit1 masked", irq_out, 1'b0);
        hw(A_IEN, 32'h2);
        #1 chk("R9 bit1 enabled", irq_out, 1'b1);
        hw(A_IFLG, 32'h1);
        hr(A_IFLG, v); chk("R8 write 0 keeps bit1", v, 32'h2);
        hw(A_IFLG, 32'h2);
        repeat (4) @(posedge clk);
        hr(A_IFLG, v); chk("R8 level held no reset", v, 0);
        chk("R9 irq low", irq_out, 1'b0);
        sub_irq = 1'b0;
        repeat (4) @(posedge clk);
        sub_irq = 1'b1;
        repeat (5) @(posedge clk);
        hr(A_IFLG, v); chk("R8 second edge", v, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule